// File: doc/BRIEF.md
# Guarded Clock Source and Divider Select Registers

This block is a small byte-wide register unit that stores two settings for a clock system: which oscillator drives the main clock, and which division factor sits between that oscillator and the system clock. A downstream glitch-free multiplexer and divider consume the two outputs. Software reaches the block through a simple bus with an address, a write strobe, a read strobe, write data and combinational read data.

The divider field can be rewritten at any time. The source field is guarded against stray writes. Software must first write a signature byte (parameter `UNLOCK_KEY`, default 0xD8) to a guard register. That write opens a short window of `WINDOW` cycles (default 4). The source register accepts a write only while the window is open. Whether or not that write lands, the window then shuts.

Address map (2-bit `addr`): 0 is the guard register, 1 is the source register, 2 is the divider register, and 3 is unused and reads zero.

Top module: `clk_cfg_regs`

## Requirements
- R1: After reset, `src_sel` is 00, `div_sel` is 0011, the source register reads 0x00, the divider register reads 0x03 and the guard register reads 0x00.
- R2: A write to address 2 loads `wdata[3:0]` into the divider field on the next clock edge, with no unlock needed. A read of address 2 returns `{4'b0, div_sel}`.
- R3: A read of address 1 returns `{6'b0, src_sel}`, so bits 7:2 always read zero. The `src_sel` encoding is 00 for the internal 8 MHz oscillator, 01 for the internal 128 kHz oscillator, 10 for the external clock and 11 for reserved.
- R4: Writing `UNLOCK_KEY` to address 0 opens the window. While the window is open, address 0 reads 0x01.
- R5: A write to address 1 at any of the `WINDOW` clock edges that follow the key write loads `wdata[1:0]` into `src_sel`, unless the code is 11.
- R6: A write to address 1 while the window is closed leaves `src_sel` unchanged. This includes a write at the edge after the `WINDOW`-th edge following the key write.
- R7: Any write to address 1 made during the window closes the window. After it, the guard register reads 0x00 and a second source write is discarded.
- R8: A write of the reserved code 11 during the window leaves `src_sel` unchanged, and it still closes the window.
- R9: Writing any value other than `UNLOCK_KEY` to address 0 does not open the window. Reads of address 3, and reads with `rd_en` low, return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| src_sel | output | 2 | Main clock source select |
| div_sel | output | 4 | Prescaler select |

## Verification
The bench targets the edges of the window:
- A source write on exactly the fourth edge after the key must land. A design with an off-by-one counter would drop it.
- A write on the fifth edge must be discarded. A design with a loose window would accept it.
- A second write inside the same window must be refused. A design that keeps the window open after use would let a stray write through.
- A wrong key must not open the window. A design that opens on any write to the guard register would fail here.
- The reserved code 11 must never reach `src_sel`.
- Re-keying while the window is open must restart the count.

Random mixes of all four addresses with a biased key value cover these cases repeatedly, and a bench model compares every output and read after every operation.

// File: rtl/clk_cfg_regs.sv
module clk_cfg_regs #(
  parameter logic [7:0] UNLOCK_KEY = 8'hD8,
  parameter int         WINDOW     = 4,
  parameter logic [3:0] DIV_RESET  = 4'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [1:0] src_sel,
  output logic [3:0] div_sel
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [1:0] A_GUARD = 2'd0;
  localparam logic [1:0] A_SRC   = 2'd1;
  localparam logic [1:0] A_DIV   = 2'd2;

  logic [CW-1:0] win_cnt;
  logic          win_open;
  logic          key_wr, src_wr, div_wr;

  assign win_open = (win_cnt != '0);
  assign key_wr   = wr_en && addr == A_GUARD && wdata == UNLOCK_KEY;
  assign src_wr   = wr_en && addr == A_SRC;
  assign div_wr   = wr_en && addr == A_DIV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              win_cnt <= '0;
    else if (key_wr)         win_cnt <= CW'(WINDOW);
    else if (src_wr)         win_cnt <= '0;
    else if (win_open)       win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_sel <= 2'b00;
    else if (src_wr && win_open && wdata[1:0] != 2'b11) src_sel <= wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_sel <= DIV_RESET;
    else if (div_wr) div_sel <= wdata[3:0];
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      case (addr)
        A_GUARD: rdata = {7'b0, win_open};
        A_SRC:   rdata = {6'b0, src_sel};
        A_DIV:   rdata = {4'b0, div_sel};
        default: rdata = 8'h00;
      endcase
    end
  end

  // R6
  src_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_wr && win_open) |=> $stable(src_sel));
  // R8
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel != 2'b11);
  // R7
  window_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_wr |=> !win_open);
  // R4
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> win_open);
  // R2
  div_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> div_sel == $past(wdata[3:0]));
  // R9
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !key_wr) |=> !win_open);
endmodule

// File: tb/clk_cfg_regs_tb.sv
module clk_cfg_regs_tb_top;
  localparam logic [7:0] KEY = 8'hD8;
  localparam int WIN = 4;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [1:0] src_sel;
  logic [3:0] div_sel;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0;
  logic [1:0] m_src = 2'b00;
  logic [3:0] m_div = 4'd3;
  logic done = 0;

  clk_cfg_regs #(.UNLOCK_KEY(KEY), .WINDOW(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .src_sel(src_sel), .div_sel(div_sel));

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {7'b0, m_cnt != 0};
      2'd1: return {6'b0, m_src};
      2'd2: return {4'b0, m_div};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic w, input logic [1:0] a, input logic [7:0] d);
    if (w && a == 2'd0 && d == KEY) m_cnt = WIN;
    else if (w && a == 2'd1) begin
      if (m_cnt != 0 && d[1:0] != 2'b11) m_src = d[1:0];
      m_cnt = 0;
    end else if (m_cnt != 0) m_cnt--;
    if (w && a == 2'd2) m_div = d[3:0];
  endtask

  task automatic op(input logic w, input logic r, input logic [1:0] a,
                    input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    if (r) chk({tag, " read"}, rdata, exp_read(a));
    @(posedge clk);
    model_edge(w, a, d);
    #1;
    wr_en = 0; rd_en = 0;
    chk({tag, " src_sel"}, {6'b0, src_sel}, {6'b0, m_src});
    chk({tag, " div_sel"}, {4'b0, div_sel}, {4'b0, m_div});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int seed;
    seed = $urandom(1234);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 src reset", {6'b0, src_sel}, 8'h00);
    chk("R1 div reset", {4'b0, div_sel}, 8'h03);
    rst_n = 1;
    op(0, 1, 2'd1, 0, "R1 src reg");
    op(0, 1, 2'd2, 0, "R1 div reg");
    op(0, 1, 2'd0, 0, "R1 guard reg");
    // R2 divider write without unlock
    op(1, 0, 2'd2, 8'hFA, "R2 div write");
    op(0, 1, 2'd2, 0, "R2 div readback");
    // R6 locked source write
    op(1, 0, 2'd1, 8'h02, "R6 locked write");
    // R4 R5 key then write on 4th edge
    op(1, 0, 2'd0, KEY, "R4 key");
    op(0, 1, 2'd0, 0, "R4 guard open");
    op(0, 0, 2'd0, 0, "R5 idle");
    op(0, 0, 2'd0, 0, "R5 idle");
    op(1, 0, 2'd1, 8'hFE, "R5 fourth edge");
    op(0, 1, 2'd1, 0, "R3 src readback");
    // R6 fifth edge rejected
    op(1, 0, 2'd0, KEY, "R6 key");
    repeat (4) op(0, 0, 2'd0, 0, "R6 idle");
    op(1, 0, 2'd1, 8'h01, "R6 fifth edge");
    // R7 second write refused
    op(1, 0, 2'd0, KEY, "R7 key");
    op(1, 0, 2'd1, 8'h01, "R7 first write");
    op(0, 1, 2'd0, 0, "R7 guard closed");
    op(1, 0, 2'd1, 8'h00, "R7 second write");
    // R8 reserved code
    op(1, 0, 2'd0, KEY, "R8 key");
    op(1, 0, 2'd1, 8'h03, "R8 reserved");
    op(1, 0, 2'd1, 8'h00, "R8 after reserved");
    // R9 wrong key, unused address
    op(1, 0, 2'd0, 8'hD9, "R9 bad key");
    op(0, 1, 2'd0, 0, "R9 guard stays");
    op(1, 0, 2'd1, 8'h02, "R9 write after bad key");
    op(0, 1, 2'd3, 0, "R9 unused addr");
    // rekey restart
    op(1, 0, 2'd0, KEY, "R5 key");
    op(0, 0, 2'd0, 0, "R5 idle");
    op(1, 0, 2'd0, KEY, "R5 rekey");
    repeat (3) op(0, 0, 2'd0, 0, "R5 idle");
    op(1, 0, 2'd1, 8'h02, "R5 after rekey");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [1:0] a;
      w = $urandom_range(0, 2) != 0;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if (a == 2'd0 && $urandom_range(0, 1) == 1) d = KEY;
      op(w, !w, a, d, "R5 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule